// File: doc/BRIEF.md
# Maskable Status Capture Register

This block gathers up to seven hardware status signals into one word that a processor can read. Each signal has its own slot, and a build-time choice fixes how that slot behaves. A live slot always shows the signal as it is now. A latching slot records any high level it sees at a clock edge and keeps it until the processor reads the word. The processor reads the word through a single read strobe.

A mask register selects which slots may raise the interrupt. Software writes the mask through a separate write strobe, and the mask is zero after reset. The interrupt output is high whenever any slot that is enabled in the mask shows a one.

The read strobe and the mask write are plain control pins. Neither has back-pressure: the read completes in the cycle the strobe is high, and the mask write takes effect at the clock edge where the write strobe is high.

Top module: `maskable_status`

## Requirements
- R1: After reset every latching slot reads 0, the mask is all zeros and `irq` is low.
- R2: A live slot (mode bit 0) shows its input on `rd_data` in the same cycle, with no register in between.
- R3: A latching slot (mode bit 1) reads 1 from the edge after which its input was sampled high, and keeps reading 1 after the input falls, for as long as no read occurs.
- R4: While `rd_stb` is high, `rd_data` shows the latched values held before the clear. At that edge every latching slot whose input is low returns to 0.
- R5: A latching slot whose input is high in the same cycle as `rd_stb` still reads 1 after that edge.
- R6: Bit i of `rd_data` carries slot i, with no reordering. Bits at position NUM_BITS and above read 0. With the default mode 7'b1010101, slots 0, 2, 4 and 6 latch and slots 1, 3 and 5 are live.
- R7: `irq` is the OR, over all slots, of the slot's value ANDed with its mask bit. It follows a live input in the same cycle, and it falls in the cycle after a read clears the masked latched bits.
- R8: The mask loads `mask_wdata` at an edge where `mask_we` is high. When `mask_we` is low, `mask_wdata` has no effect on the mask or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_in | input | NUM_BITS | Hardware status signals, one per slot |
| rd_stb | input | 1 | Read strobe; clears the latching slots at the edge |
| rd_data | output | 8 | Status word; unused upper bits are 0 |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_BITS | New mask value |
| irq | output | 1 | Interrupt, high while any masked slot shows 1 |

## Verification
The case that matters most is a read that falls in the same cycle as a new high level on a latching input. In that cycle the clear and the capture compete for the same flop. The bench provokes it by holding one latching input high through the read-strobe cycle while a second latched slot has an input that is already low. It then requires that the word read during the strobe shows both bits, and that the word read afterwards still holds the first bit but has dropped the second. A similar overlap exists between a mask write and an `irq` change. This is judged by checking that `irq` responds only from the edge where the write strobe is high.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  localparam int unsigned STS_MAX_BITS = 7;
  localparam int unsigned STS_RD_W     = STS_MAX_BITS + 1;
endpackage

// File: rtl/stsreg_hold.sv
module stsreg_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic clr,
  output logic held
);
  logic held_q;

  // a read clears the bit, but an input that is high on that edge wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= 1'b0;
    else if (clr) held_q <= sig_in;
    else          held_q <= held_q | sig_in;
  end

  assign held = held_q;
endmodule

// File: rtl/stsreg_mask.sv
module stsreg_mask #(
  parameter int unsigned NUM_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [NUM_BITS-1:0] wdata,
  output logic [NUM_BITS-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask <= '0;
    else if (we) mask <= wdata;
  end
endmodule

// File: rtl/stsreg_irq.sv
module stsreg_irq #(
  parameter int unsigned NUM_BITS = 7
) (
  input  logic [NUM_BITS-1:0] view,
  input  logic [NUM_BITS-1:0] mask,
  output logic                irq
);
  assign irq = |(view & mask);
endmodule

// File: rtl/maskable_status.sv
module maskable_status #(
  parameter int unsigned          NUM_BITS    = 7,
  parameter logic [NUM_BITS-1:0]  STICKY_MODE = 7'b1010101
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BITS-1:0]               stat_in,
  input  logic                              rd_stb,
  output logic [stsreg_pkg::STS_RD_W-1:0]   rd_data,
  input  logic                              mask_we,
  input  logic [NUM_BITS-1:0]               mask_wdata,
  output logic                              irq
);
  localparam int unsigned RD_W  = stsreg_pkg::STS_RD_W;
  localparam int unsigned PAD_W = RD_W - NUM_BITS;

  logic [NUM_BITS-1:0] view;
  logic [NUM_BITS-1:0] mask;

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_slot
    if (STICKY_MODE[i]) begin : g_latch
      stsreg_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (stat_in[i]),
        .clr    (rd_stb),
        .held   (view[i])
      );
    end else begin : g_live
      assign view[i] = stat_in[i];
    end
  end

  stsreg_mask #(.NUM_BITS(NUM_BITS)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mask_we),
    .wdata (mask_wdata),
    .mask  (mask)
  );

  stsreg_irq #(.NUM_BITS(NUM_BITS)) u_irq (
    .view (view),
    .mask (mask),
    .irq  (irq)
  );

  assign rd_data = {{PAD_W{1'b0}}, view};
endmodule

// File: rtl/stsreg_chk.sv
module stsreg_chk #(
  parameter int unsigned         NUM_BITS    = 7,
  parameter logic [NUM_BITS-1:0] STICKY_MODE = 7'b1010101
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_BITS-1:0] stat_in,
  input logic                rd_stb,
  input logic [7:0]          rd_data,
  input logic                mask_we,
  input logic [NUM_BITS-1:0] mask_wdata,
  input logic                irq
);
  logic [NUM_BITS-1:0] shadow_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_mask <= '0;
    else if (mask_we) shadow_mask <= mask_wdata;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(rd_data[NUM_BITS-1:0] & shadow_mask));

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:NUM_BITS] == '0);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    if (STICKY_MODE[i]) begin : g_latch
      // R3
      latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_in[i] |=> rd_data[i]);
      // R4
      read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !stat_in[i]) |=> !rd_data[i]);
      // R5
      read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && stat_in[i]) |=> rd_data[i]);
    end else begin : g_live
      // R2
      live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[i] == stat_in[i]);
    end
  end
endmodule

bind maskable_status stsreg_chk #(
  .NUM_BITS    (NUM_BITS),
  .STICKY_MODE (STICKY_MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stat_in    (stat_in),
  .rd_stb     (rd_stb),
  .rd_data    (rd_data),
  .mask_we    (mask_we),
  .mask_wdata (mask_wdata),
  .irq        (irq)
);

// File: tb/maskable_status_test.sv
module maskable_status_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] stat_in = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       mask_we = 1'b0;
  logic [6:0] mask_wdata = '0;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  maskable_status uut (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .rd_stb(rd_stb),
    .rd_data(rd_data), .mask_we(mask_we), .mask_wdata(mask_wdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // move to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    #2;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_live();
    stat_in = 7'h02; #2;
    chk("R2 live high", rd_data, 8'h02);
    stat_in = 7'h00; #2;
    chk("R2 live low", rd_data, 8'h00);
    tick();
  endtask

  task automatic t_capture();
    stat_in = 7'h04; #2;
    chk("R3 before edge", rd_data, 8'h00);
    tick();
    stat_in = 7'h00; #2;
    chk("R3 captured", rd_data, 8'h04);
    repeat (3) tick();
    chk("R3 holds", rd_data, 8'h04);
  endtask

  task automatic t_read_clear();
    rd_stb = 1'b1; #2;
    chk("R4 pre-clear view", rd_data, 8'h04);
    tick();
    rd_stb = 1'b0; #2;
    chk("R4 cleared", rd_data, 8'h00);
  endtask

  task automatic t_collide();
    stat_in = 7'h11;
    tick();
    stat_in = 7'h00; #2;
    chk("R5 setup", rd_data, 8'h11);
    rd_stb = 1'b1; stat_in = 7'h01; #2;
    chk("R5 read cycle view", rd_data, 8'h11);
    tick();
    rd_stb = 1'b0; stat_in = 7'h00; #2;
    chk("R5 kept bit0 dropped bit4", rd_data, 8'h01);
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0; #2;
    chk("R4 second clear", rd_data, 8'h00);
  endtask

  task automatic t_order();
    stat_in = 7'h7F; #2;
    chk("R6 live slots only", rd_data, 8'h2A);
    tick();
    stat_in = 7'h00; #2;
    chk("R6 latched slots", rd_data, 8'h55);
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0; #2;
    chk("R6 cleared", rd_data, 8'h00);
  endtask

  task automatic t_irq();
    stat_in = 7'h02; #2;
    chk("R1 mask zero blocks irq", {7'b0, irq}, 8'h00);
    mask_wdata = 7'h02;
    tick(); #2;
    chk("R8 no write without strobe", {7'b0, irq}, 8'h00);
    mask_we = 1'b1;
    tick();
    mask_we = 1'b0; #2;
    chk("R8 mask written", {7'b0, irq}, 8'h01);
    stat_in = 7'h00; #2;
    chk("R7 live drop same cycle", {7'b0, irq}, 8'h00);
    mask_we = 1'b1; mask_wdata = 7'h10;
    tick();
    mask_we = 1'b0; mask_wdata = 7'h7F;
    stat_in = 7'h10; #2;
    chk("R7 latched not yet set", {7'b0, irq}, 8'h00);
    tick();
    stat_in = 7'h00; #2;
    chk("R7 latched raises irq", {7'b0, irq}, 8'h01);
    rd_stb = 1'b1; #2;
    chk("R7 irq during read", {7'b0, irq}, 8'h01);
    tick();
    rd_stb = 1'b0; #2;
    chk("R7 irq after read", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_live();
    t_capture();
    t_read_clear();
    t_collide();
    t_order();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule